// File: doc/BRIEF.md
# RF Station Interlock Sequencer

This block is the safety sequencer for one high-power RF station. It gathers a vector of interlock inputs and folds them into one sum interlock. An input takes part only when its external bypass strap is open. In conditioning mode, the inputs that carry machine-protection alarms are left out as well. The block steps the station from standby, through a state with high voltage on and the trigger held off, through a timed synchronising wait, and into RF-ready. Only in RF-ready is the modulator trigger passed on.

The operating mode is written over the control link. It selects beam operation, conditioning, RF-load test or diode operation. Conditioning holds back each station trigger by a fixed number of cycles. Diode mode keeps RF drive off while the high-voltage path still runs. The first interlock that fires is latched with the number of its input. The latch holds until the control link clears it, and a clear is accepted only while the sum interlock is quiet. Both the wait and the trigger delay are given in time units and are turned into clock cycles from a clock-rate parameter. A bench can therefore shorten them.

Top module: `rf_ilk_seq`

## Requirements
- R1: `sum_ilk` is high exactly when some input has `ilk_in` high and `ilk_bypass` low. A bypassed input never raises it, never latches a fault and never moves the state.
- R2: In conditioning mode (mode code 1), the inputs flagged in the `MPS_SEL` parameter (default bits 7 and 6) do not take part in the sum. In all other modes they do.
- R3: On the first cycle the sum is high with no fault latched, `fault_valid` rises. `fault_idx` then holds the lowest active input index. Both hold until `ilk_reset` is pulsed while the sum is low. A reset given while the sum is high is ignored.
- R4: A sum interlock in the synchronising wait (state 2) or in RF-ready (state 3) moves the state to high-voltage-on (state 1) at the next edge. If a high-voltage input is among the active ones (`HV_SEL`, default bits 1 and 0), the state moves to standby (state 0) instead.
- R5: In standby, `hv_enable` is low. In every other state it is high. In states 0 to 2, `trig_out` stays low.
- R6: From high-voltage-on, with `hv_req` and `rf_req` high and no interlock active or latched, the state enters the wait. It stays there exactly `SYNC_CYC` cycles and then enters RF-ready.
- R7: In RF-ready, outside conditioning mode, a `trig_in` pulse appears on `trig_out` one cycle later. `rf_enable` is high in RF-ready except in diode mode (code 3).
- R8: In RF-ready in conditioning mode, `trig_out` fires `TRIG_CYC` cycles later than it would in other modes.
- R9: A mode write of a new value during the wait or in RF-ready drops the state to high-voltage-on. The new mode is shown on `mode_o` one cycle after that. A write of the current value has no effect. Mode codes: 0 beam, 1 conditioning, 2 load, 3 diode.
- R10: While a fault is latched, the state does not move upward out of standby or high-voltage-on.
- R11: With `hv_req` low, the state goes to standby at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilk_in | input | N_ILK | Interlock inputs, high = fault |
| ilk_bypass | input | N_ILK | Bypass straps, high = input unused |
| hv_req | input | 1 | Request high voltage on |
| rf_req | input | 1 | Request RF operation |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 2 | Mode value written |
| ilk_reset | input | 1 | Fault latch clear strobe |
| trig_in | input | 1 | Station trigger pulse |
| sum_ilk | output | 1 | Sum interlock |
| fault_valid | output | 1 | A fault is latched |
| fault_idx | output | IDX_W | Index of the latched first fault |
| state_o | output | 2 | Station state code |
| mode_o | output | 2 | Active mode code |
| hv_enable | output | 1 | Modulator high voltage enable |
| rf_enable | output | 1 | RF drive permit |
| trig_out | output | 1 | Gated trigger to modulator |

## Verification
Three actions can land on the same clock edge in RF-ready: an interlock, a mode write and a trigger. The bench raises a high-voltage interlock, a mode write and `trig_in` together in that state. It then expects three things at the next edge: standby, no trigger, and fault index 0. The pending mode must then appear only on the following edge. A second collision pairs a clear request with an interlock that is still active. The latch must survive it.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  typedef enum logic [1:0] {
    MODE_BEAM  = 2'd0,
    MODE_COND  = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_DIODE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_HVON    = 2'd1,
    ST_SYNC    = 2'd2,
    ST_READY   = 2'd3
  } state_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction
endpackage

// File: rtl/rfi_ilk.sv
module rfi_ilk #(
  parameter int N_ILK = 8,
  parameter int IDX_W = 3,
  parameter logic [N_ILK-1:0] MPS_SEL = '0,
  parameter logic [N_ILK-1:0] HV_SEL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ILK-1:0] ilk_in,
  input  logic [N_ILK-1:0] bypass,
  input  logic             cond_mode,
  input  logic             ilk_reset,
  output logic             sum_ilk,
  output logic             hv_hit,
  output logic             fault_valid,
  output logic [IDX_W-1:0] fault_idx
);
  logic [N_ILK-1:0] live;
  logic [IDX_W-1:0] first_idx;
  logic             valid_d;
  logic [IDX_W-1:0] idx_d;
  logic             upd_en;

  always_comb begin
    live    = ilk_in & ~bypass & ~(cond_mode ? MPS_SEL : '0);
    sum_ilk = |live;
    hv_hit  = |(live & HV_SEL);
  end

  always_comb begin
    first_idx = '0;
    for (int i = N_ILK - 1; i >= 0; i--) begin
      if (live[i]) first_idx = IDX_W'(i);
    end
  end

  always_comb begin
    valid_d = fault_valid;
    idx_d   = fault_idx;
    upd_en  = 1'b0;
    if (!fault_valid && sum_ilk) begin
      valid_d = 1'b1;
      idx_d   = first_idx;
      upd_en  = 1'b1;
    end else if (fault_valid && ilk_reset && !sum_ilk) begin
      valid_d = 1'b0;
      upd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_valid <= 1'b0;
      fault_idx   <= '0;
    end else if (upd_en) begin
      fault_valid <= valid_d;
      fault_idx   <= idx_d;
    end
  end
endmodule

// File: rtl/rfi_mode.sv
module rfi_mode
  import rfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  input  logic       in_run,
  output mode_e      mode_cur,
  output logic       pend,
  output logic       chg_req
);
  mode_e mode_d, pend_val, pend_val_d;
  logic  pend_d;
  logic  upd_en;

  assign chg_req = mode_wr && (mode_sel != mode_cur) && in_run;

  always_comb begin
    mode_d     = mode_cur;
    pend_d     = pend;
    pend_val_d = pend_val;
    upd_en     = 1'b0;
    if (mode_wr && !in_run) begin
      mode_d = mode_e'(mode_sel);
      pend_d = 1'b0;
      upd_en = 1'b1;
    end else if (chg_req) begin
      pend_d     = 1'b1;
      pend_val_d = mode_e'(mode_sel);
      upd_en     = 1'b1;
    end else if (pend && !in_run) begin
      mode_d = pend_val;
      pend_d = 1'b0;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cur <= MODE_BEAM;
      pend     <= 1'b0;
      pend_val <= MODE_BEAM;
    end else if (upd_en) begin
      mode_cur <= mode_d;
      pend     <= pend_d;
      pend_val <= pend_val_d;
    end
  end
endmodule

// File: rtl/rfi_fsm.sv
module rfi_fsm
  import rfi_pkg::*;
#(
  parameter int SYNC_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hv_req,
  input  logic   rf_req,
  input  logic   sum_ilk,
  input  logic   hv_hit,
  input  logic   fault_valid,
  input  logic   chg_req,
  input  logic   pend,
  output state_e state
);
  localparam int CNT_W = $clog2(SYNC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYC - 1);

  state_e           state_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             cnt_en;
  logic             clean;

  assign clean = !sum_ilk && !fault_valid;

  always_comb begin
    state_d = state;
    if (!hv_req) begin
      state_d = ST_STANDBY;
    end else begin
      unique case (state)
        ST_STANDBY: if (clean) state_d = ST_HVON;
        ST_HVON: begin
          if (sum_ilk && hv_hit)              state_d = ST_STANDBY;
          else if (rf_req && clean && !pend)  state_d = ST_SYNC;
        end
        ST_SYNC, ST_READY: begin
          if (sum_ilk)                 state_d = hv_hit ? ST_STANDBY : ST_HVON;
          else if (chg_req || !rf_req) state_d = ST_HVON;
          else if (state == ST_SYNC && cnt == CNT_LAST) state_d = ST_READY;
        end
        default: state_d = ST_STANDBY;
      endcase
    end
  end

  always_comb begin
    cnt_en = (state == ST_SYNC) || (cnt != '0);
    cnt_d  = (state == ST_SYNC) ? cnt + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_STANDBY;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/rfi_trig.sv
module rfi_trig #(
  parameter int TRIG_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic ready,
  input  logic cond_mode,
  output logic trig_out
);
  localparam int CNT_W = $clog2(TRIG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIG_CYC - 1);

  logic             busy, busy_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             trig_q, trig_d;
  logic             start, fire;

  always_comb begin
    start  = trig_in && ready && cond_mode && !busy;
    fire   = busy && ready && (cnt == CNT_LAST);
    trig_d = (trig_in && ready && !cond_mode) || fire;
    busy_d = busy;
    cnt_d  = cnt;
    if (!ready || fire) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      trig_q <= 1'b0;
    end else begin
      busy   <= busy_d;
      cnt    <= cnt_d;
      trig_q <= trig_d;
    end
  end

  assign trig_out = trig_q && ready;
endmodule

// File: rtl/rf_ilk_seq.sv
module rf_ilk_seq
  import rfi_pkg::*;
#(
  parameter int N_ILK        = 8,
  parameter int CLK_HZ       = 125_000_000,
  parameter int SYNC_WAIT_US = 5000,
  parameter int TRIG_DLY_NS  = 2000,
  parameter logic [N_ILK-1:0] MPS_SEL = 'hC0,
  parameter logic [N_ILK-1:0] HV_SEL  = 'h03,
  localparam int IDX_W = (N_ILK > 1) ? $clog2(N_ILK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ILK-1:0] ilk_in,
  input  logic [N_ILK-1:0] ilk_bypass,
  input  logic             hv_req,
  input  logic             rf_req,
  input  logic             mode_wr,
  input  logic [1:0]       mode_sel,
  input  logic             ilk_reset,
  input  logic             trig_in,
  output logic             sum_ilk,
  output logic             fault_valid,
  output logic [IDX_W-1:0] fault_idx,
  output logic [1:0]       state_o,
  output logic [1:0]       mode_o,
  output logic             hv_enable,
  output logic             rf_enable,
  output logic             trig_out
);
  localparam int KHZ      = CLK_HZ / 1000;
  localparam int SYNC_CYC = at_least_one(KHZ * SYNC_WAIT_US / 1000);
  localparam int TRIG_CYC = at_least_one(KHZ * TRIG_DLY_NS / 1_000_000);

  logic   [1:0] rst_pipe;
  logic         rst_ni;
  logic         hv_hit, cond_mode, in_run, pend, chg_req;
  mode_e        mode_cur;
  state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign cond_mode = (mode_cur == MODE_COND);
  assign in_run    = (state == ST_SYNC) || (state == ST_READY);

  rfi_ilk #(.N_ILK(N_ILK), .IDX_W(IDX_W), .MPS_SEL(MPS_SEL), .HV_SEL(HV_SEL)) u_ilk (
    .clk(clk), .rst_n(rst_ni), .ilk_in(ilk_in), .bypass(ilk_bypass),
    .cond_mode(cond_mode), .ilk_reset(ilk_reset), .sum_ilk(sum_ilk),
    .hv_hit(hv_hit), .fault_valid(fault_valid), .fault_idx(fault_idx)
  );

  rfi_mode u_mode (
    .clk(clk), .rst_n(rst_ni), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .in_run(in_run), .mode_cur(mode_cur), .pend(pend), .chg_req(chg_req)
  );

  rfi_fsm #(.SYNC_CYC(SYNC_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_ni), .hv_req(hv_req), .rf_req(rf_req),
    .sum_ilk(sum_ilk), .hv_hit(hv_hit), .fault_valid(fault_valid),
    .chg_req(chg_req), .pend(pend), .state(state)
  );

  rfi_trig #(.TRIG_CYC(TRIG_CYC)) u_trig (
    .clk(clk), .rst_n(rst_ni), .trig_in(trig_in),
    .ready(state == ST_READY), .cond_mode(cond_mode), .trig_out(trig_out)
  );

  assign state_o   = state;
  assign mode_o    = mode_cur;
  assign hv_enable = (state != ST_STANDBY);
  assign rf_enable = (state == ST_READY) && (mode_cur != MODE_DIODE);
endmodule

// File: rtl/rf_ilk_seq_chk.sv
module rf_ilk_seq_chk #(
  parameter int N_ILK = 8,
  parameter logic [N_ILK-1:0] MPS_SEL = 'hC0,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_ILK-1:0] ilk_in,
  input logic [N_ILK-1:0] ilk_bypass,
  input logic             hv_req,
  input logic             ilk_reset,
  input logic             trig_in,
  input logic             sum_ilk,
  input logic             fault_valid,
  input logic [IDX_W-1:0] fault_idx,
  input logic [1:0]       state_o,
  input logic [1:0]       mode_o,
  input logic             hv_enable,
  input logic             rf_enable,
  input logic             trig_out
);
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sum_ilk |-> |(ilk_in & ~ilk_bypass)); // R1

  AST_COND_MPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_ilk && mode_o == 2'd1) |-> |(ilk_in & ~ilk_bypass & ~MPS_SEL)); // R2

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !ilk_reset) |=> (fault_valid && $stable(fault_idx))); // R3

  AST_ILK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_ilk && state_o[1]) |=> !state_o[1]); // R4

  AST_STANDBY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |-> (!hv_enable && !trig_out)); // R5

  AST_READY_VIA_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && $past(state_o) != 2'd3) |-> $past(state_o) == 2'd2); // R6

  AST_DIRECT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(mode_o) != 2'd1) |-> $past(trig_in)); // R7

  AST_DIODE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> !rf_enable); // R7

  AST_HV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_req |=> (state_o == 2'd0)); // R11
endmodule

bind rf_ilk_seq rf_ilk_seq_chk #(.N_ILK(N_ILK), .MPS_SEL(MPS_SEL), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ilk_in(ilk_in), .ilk_bypass(ilk_bypass),
  .hv_req(hv_req), .ilk_reset(ilk_reset), .trig_in(trig_in),
  .sum_ilk(sum_ilk), .fault_valid(fault_valid), .fault_idx(fault_idx),
  .state_o(state_o), .mode_o(mode_o), .hv_enable(hv_enable),
  .rf_enable(rf_enable), .trig_out(trig_out)
);

// File: tb/rf_ilk_seq_tb.sv
module rf_ilk_seq_tb;
  localparam int W = 6;  // sync wait cycles with the bench timebase
  localparam int D = 3;  // conditioning trigger delay cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ilk_in, ilk_bypass;
  logic       hv_req, rf_req, mode_wr, ilk_reset, trig_in;
  logic [1:0] mode_sel;
  logic       sum_ilk, fault_valid, hv_enable, rf_enable, trig_out;
  logic [2:0] fault_idx;
  logic [1:0] state_o, mode_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rf_ilk_seq #(.N_ILK(8), .CLK_HZ(1_000_000), .SYNC_WAIT_US(W),
               .TRIG_DLY_NS(D * 1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .ilk_in(ilk_in), .ilk_bypass(ilk_bypass),
    .hv_req(hv_req), .rf_req(rf_req), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .ilk_reset(ilk_reset), .trig_in(trig_in), .sum_ilk(sum_ilk),
    .fault_valid(fault_valid), .fault_idx(fault_idx), .state_o(state_o),
    .mode_o(mode_o), .hv_enable(hv_enable), .rf_enable(rf_enable),
    .trig_out(trig_out)
  );

  // {mode[1:0], ilk[7:0], bypass[7:0], expected sum}
  localparam logic [18:0] VEC [12] = '{
    {2'd0, 8'h00, 8'h00, 1'b0}, {2'd0, 8'h01, 8'h00, 1'b1},
    {2'd0, 8'h01, 8'h01, 1'b0}, {2'd0, 8'h80, 8'h00, 1'b1},
    {2'd1, 8'h80, 8'h00, 1'b0}, {2'd1, 8'h40, 8'h00, 1'b0},
    {2'd1, 8'h48, 8'h00, 1'b1}, {2'd1, 8'h48, 8'h08, 1'b0},
    {2'd2, 8'h40, 8'h00, 1'b1}, {2'd3, 8'hFF, 8'hFF, 1'b0},
    {2'd3, 8'hFF, 8'hFE, 1'b1}, {2'd0, 8'h10, 8'hEF, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_sel = m; mode_wr = 1'b1;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic clear_fault();
    ilk_reset = 1'b1;
    tick();
    ilk_reset = 1'b0;
  endtask

  task automatic go_ready();
    hv_req = 1'b1; rf_req = 1'b1;
    for (int k = 0; k < 40 && state_o != 2'd3; k++) tick();
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    tick();
    trig_in = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ilk_in = '0; ilk_bypass = '0; hv_req = 1'b0; rf_req = 1'b0;
    mode_wr = 1'b0; mode_sel = '0; ilk_reset = 1'b0; trig_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // reset state
    check("R5 reset state", state_o, 0);
    check("R5 reset hv_enable", hv_enable, 0);
    check("R3 reset fault_valid", fault_valid, 0);
    check("R9 reset mode", mode_o, 0);
    check("R7 reset rf_enable", rf_enable, 0);

    // sum interlock table, station held in standby
    foreach (VEC[i]) begin
      write_mode(VEC[i][18:17]);
      ilk_in = VEC[i][16:9]; ilk_bypass = VEC[i][8:1];
      #1;
      check($sformatf("R1/R2 vector %0d sum", i), sum_ilk, VEC[i][0]);
      check($sformatf("R11 vector %0d standby", i), state_o, 0);
      tick();
    end
    ilk_in = '0; ilk_bypass = '0;
    clear_fault();
    check("R3 clear after table", fault_valid, 0);
    write_mode(2'd0);

    // R5 / R6 climb
    hv_req = 1'b1; rf_req = 1'b1;
    tick();
    check("R5 hv-on state", state_o, 1);
    check("R5 hv-on hv_enable", hv_enable, 1);
    tick();
    check("R6 entered sync", state_o, 2);
    repeat (W - 1) tick();
    check("R6 still in sync", state_o, 2);
    tick();
    check("R6 ready after wait", state_o, 3);
    check("R7 rf_enable beam", rf_enable, 1);

    // R7 direct trigger
    pulse_trig();
    check("R7 trigger one cycle later", trig_out, 1);
    tick();
    check("R7 trigger single pulse", trig_out, 0);

    // R1 bypassed input in ready
    ilk_in = 8'h10; ilk_bypass = 8'h10;
    tick();
    check("R1 bypass keeps ready", state_o, 3);
    check("R1 bypass no fault", fault_valid, 0);
    ilk_in = '0; ilk_bypass = '0;

    // R9 mode change in ready
    write_mode(2'd1);
    check("R9 dropped to hv-on", state_o, 1);
    check("R9 mode not yet applied", mode_o, 0);
    tick();
    check("R9 mode applied", mode_o, 1);
    go_ready();
    check("R9 ready again", state_o, 3);

    // R8 delayed trigger
    pulse_trig();
    check("R8 no immediate trigger", trig_out, 0);
    repeat (D - 1) tick();
    check("R8 still waiting", trig_out, 0);
    tick();
    check("R8 delayed trigger", trig_out, 1);
    tick();
    check("R8 trigger ends", trig_out, 0);

    // R2 machine protection alarm ignored in conditioning
    ilk_in = 8'h80;
    tick();
    check("R2 mps masked keeps ready", state_o, 3);
    check("R2 mps masked no fault", fault_valid, 0);
    ilk_in = '0;

    // R4 ordinary interlock
    ilk_in = 8'h08;
    tick();
    check("R4 drop to hv-on", state_o, 1);
    check("R3 fault latched", fault_valid, 1);
    check("R3 fault index", fault_idx, 3);
    ilk_in = '0;
    repeat (2) tick();
    check("R10 held by latched fault", state_o, 1);

    // R3 reset ignored while active
    ilk_in = 8'h08;
    clear_fault();
    check("R3 reset ignored while active", fault_valid, 1);
    ilk_in = '0;
    clear_fault();
    check("R3 reset accepted", fault_valid, 0);

    // R3 priority of simultaneous inputs
    ilk_in = 8'h24;
    tick();
    check("R3 lowest index wins", fault_idx, 2);
    ilk_in = '0;
    clear_fault();

    // diode mode
    write_mode(2'd3);
    go_ready();
    check("R6 ready in diode", state_o, 3);
    check("R7 no rf in diode", rf_enable, 0);
    pulse_trig();
    check("R7 trigger in diode", trig_out, 1);
    write_mode(2'd3);
    check("R9 same value write no effect", state_o, 3);

    // collision: HV interlock, mode write and trigger on one edge
    mode_sel = 2'd0; mode_wr = 1'b1; ilk_in = 8'h01; trig_in = 1'b1;
    tick();
    mode_wr = 1'b0; trig_in = 1'b0;
    check("R4 hv fault to standby", state_o, 0);
    check("R5 standby no trigger", trig_out, 0);
    check("R3 hv fault index", fault_idx, 0);
    check("R9 mode still pending", mode_o, 3);
    tick();
    check("R9 pending mode applied", mode_o, 0);
    ilk_in = '0;
    clear_fault();

    // R11 high voltage request withdrawn
    go_ready();
    check("R11 ready before drop", state_o, 3);
    hv_req = 1'b0;
    tick();
    check("R11 standby on hv_req low", state_o, 0);
    check("R5 hv off in standby", hv_enable, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule